// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block sits on the controller side of an SDRAM interface. It decides when an auto-refresh command is due and sequences its issue. A programmable cycle divider produces a refresh tick at a fixed interval. Each tick adds one entry to a small pending count, and a request to the command arbiter stays raised until the arbiter grants it. Once granted, the scheduler checks the per-bank idle flags. If any bank is still open, it first emits a precharge-all command. It issues the refresh only when every bank reports idle. It then holds off all other commands for a programmable refresh-cycle time.

The device generates the refresh row and bank address on its own and advances it with each refresh command. So the scheduler drives no address and only counts commands. A refresh leaves every bank precharged, so no precharge follows a refresh. A 12-bit count of refreshes in the current retention window wraps after 4096 commands, which is one full sweep of the array. A one-cycle pulse marks that wrap.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After a synchronous reset, ref_req, pre_all_cmd, ref_cmd, cmd_block and sweep_done are 0 and ref_count is 0.
- R2: A refresh tick occurs every interval_cfg clock cycles, with a value of 0 treated as 1. With the grant held and all banks idle, successive ref_cmd pulses are exactly interval_cfg cycles apart.
- R3: Once raised, ref_req stays high until the refresh it requests has completed. While ref_gnt is low, neither ref_cmd nor pre_all_cmd is issued.
- R4: ref_cmd is issued only in the cycle after one in which all bits of bank_idle were 1 and ref_gnt was 1. If a bank is open when the grant arrives, pre_all_cmd pulses for exactly one cycle first, and ref_cmd follows one cycle after bank_idle becomes all ones.
- R5: No pre_all_cmd is issued between a ref_cmd and the end of its cmd_block window.
- R6: cmd_block is high for exactly trfc_cfg cycles, with 0 treated as 1, starting with the ref_cmd cycle. ref_req falls in the same cycle that cmd_block falls.
- R7: Each ref_cmd pulse raises ref_count by one in the next cycle. At 4096 refreshes the count wraps to 0, and sweep_done is high for that one cycle only.
- R8: Ticks that arrive while a refresh is waiting are held in a pending count (up to PEND_MAX). Each held tick later produces its own ref_cmd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_cfg | input | DIV_W (16) | Cycles between refresh ticks |
| trfc_cfg | input | TRFC_W (8) | Refresh-cycle hold-off length in cycles |
| bank_idle | input | NUM_BANKS (4) | One flag per bank, 1 = bank precharged |
| ref_gnt | input | 1 | Arbiter grant for the refresh request |
| ref_req | output | 1 | Refresh request to the arbiter |
| pre_all_cmd | output | 1 | One-cycle precharge-all command |
| ref_cmd | output | 1 | One-cycle auto-refresh command |
| cmd_block | output | 1 | High while other commands must be held off |
| ref_count | output | CNT_W (12) | Refreshes issued in the current sweep |
| sweep_done | output | 1 | One-cycle pulse when the count wraps |

## Verification
A divider that is off by one shows up as ref_cmd spacing that differs from interval_cfg, starting from the second refresh after reset. A faulty pending count shows up as a missing or extra ref_cmd right after a held grant is released. A faulty hold-off counter shows a cmd_block window of the wrong length within trfc_cfg cycles of the refresh. A wrong sweep count shows up as a ref_count value that does not match one cycle after a ref_cmd, or as sweep_done arriving at some refresh other than the 4096th.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_PRE  = 2'd2,
    ST_RFC  = 2'd3
  } sched_st_t;
endpackage

// File: rtl/sched_tick_gen.sv
module sched_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] interval_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] last_val;

  // An interval of 0 behaves like an interval of 1.
  assign last_val = (interval_cfg == '0) ? '0 : interval_cfg - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= last_val) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end
endmodule

// File: rtl/sched_ref_fsm.sv
module sched_ref_fsm
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRFC_W    = 8,
  parameter int PEND_MAX  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [TRFC_W-1:0]    trfc_cfg,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 pre_all_cmd,
  output logic                 ref_cmd,
  output logic                 cmd_block
);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  sched_st_t         st;
  logic [PEND_W-1:0] pend;
  logic [TRFC_W-1:0] rfc_cnt;
  logic              all_idle;
  logic              issue_ref;
  logic              issue_pre;
  logic              pend_inc;

  assign all_idle  = &bank_idle;
  assign issue_ref = ref_gnt && all_idle && (st == ST_REQ || st == ST_PRE);
  assign issue_pre = ref_gnt && !all_idle && (st == ST_REQ);
  assign pend_inc  = tick && (pend != PEND_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      case ({pend_inc, issue_ref})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ref_req     <= 1'b0;
      pre_all_cmd <= 1'b0;
      ref_cmd     <= 1'b0;
      cmd_block   <= 1'b0;
      rfc_cnt     <= '0;
    end else begin
      pre_all_cmd <= 1'b0;
      ref_cmd     <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (pend != '0) begin
            st      <= ST_REQ;
            ref_req <= 1'b1;
          end
        end
        ST_REQ, ST_PRE: begin
          if (issue_ref) begin
            st        <= ST_RFC;
            ref_cmd   <= 1'b1;
            cmd_block <= 1'b1;
            rfc_cnt   <= (trfc_cfg == '0) ? TRFC_W'(1) : trfc_cfg;
          end else if (issue_pre) begin
            st          <= ST_PRE;
            pre_all_cmd <= 1'b1;
          end
        end
        ST_RFC: begin
          if (rfc_cnt <= TRFC_W'(1)) begin
            st        <= ST_IDLE;
            cmd_block <= 1'b0;
            ref_req   <= 1'b0;
          end else begin
            rfc_cnt <= rfc_cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sched_sweep_ctr.sv
module sched_sweep_ctr #(
  parameter int SWEEP_COUNT = 4096,
  parameter int CNT_W       = $clog2(SWEEP_COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_cmd,
  output logic [CNT_W-1:0] ref_count,
  output logic             sweep_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SWEEP_COUNT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_count  <= '0;
      sweep_done <= 1'b0;
    end else if (ref_cmd) begin
      if (ref_count == LAST) begin
        ref_count  <= '0;
        sweep_done <= 1'b1;
      end else begin
        ref_count  <= ref_count + 1'b1;
        sweep_done <= 1'b0;
      end
    end else begin
      sweep_done <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int NUM_BANKS   = 4,
  parameter int DIV_W       = 16,
  parameter int TRFC_W      = 8,
  parameter int PEND_MAX    = 8,
  parameter int SWEEP_COUNT = 4096,
  parameter int CNT_W       = $clog2(SWEEP_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     interval_cfg,
  input  logic [TRFC_W-1:0]    trfc_cfg,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 pre_all_cmd,
  output logic                 ref_cmd,
  output logic                 cmd_block,
  output logic [CNT_W-1:0]     ref_count,
  output logic                 sweep_done
);
  logic tick;

  sched_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk          (clk),
    .rst          (rst),
    .interval_cfg (interval_cfg),
    .tick         (tick)
  );

  sched_ref_fsm #(
    .NUM_BANKS (NUM_BANKS),
    .TRFC_W    (TRFC_W),
    .PEND_MAX  (PEND_MAX)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .trfc_cfg    (trfc_cfg),
    .bank_idle   (bank_idle),
    .ref_gnt     (ref_gnt),
    .ref_req     (ref_req),
    .pre_all_cmd (pre_all_cmd),
    .ref_cmd     (ref_cmd),
    .cmd_block   (cmd_block)
  );

  sched_sweep_ctr #(
    .SWEEP_COUNT (SWEEP_COUNT),
    .CNT_W       (CNT_W)
  ) u_sweep (
    .clk        (clk),
    .rst        (rst),
    .ref_cmd    (ref_cmd),
    .ref_count  (ref_count),
    .sweep_done (sweep_done)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] bank_idle,
  input logic                 ref_gnt,
  input logic                 ref_req,
  input logic                 pre_all_cmd,
  input logic                 ref_cmd,
  input logic                 cmd_block,
  input logic [CNT_W-1:0]     ref_count,
  input logic                 sweep_done
);
  // R3: an ungranted request is not withdrawn
  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

  // R3: commands only under a grant
  p_cmd_needs_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    (ref_cmd || pre_all_cmd) |-> $past(ref_gnt));

  // R4: refresh only after all banks reported idle
  p_ref_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> $past(&bank_idle));

  // R4: precharge and refresh never together
  p_cmd_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_cmd, pre_all_cmd}));

  // R5: no precharge inside the hold-off window
  p_no_pre_in_rfc_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_block |-> !pre_all_cmd);

  // R6: hold-off starts with the refresh
  p_block_start_r6: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> cmd_block && ref_req);

  // R6: request drops together with the hold-off
  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_block) |-> !ref_req);

  // R7: a wrap pulse follows a refresh and leaves the count at zero
  p_sweep_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> (ref_count == '0) && $past(ref_cmd));

  // R7: count moves only after a refresh
  p_count_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(ref_cmd) |-> $stable(ref_count));
endmodule

bind sdram_refresh_sched sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .CNT_W     (CNT_W)
) u_sched_chk (
  .clk         (clk),
  .rst         (rst),
  .bank_idle   (bank_idle),
  .ref_gnt     (ref_gnt),
  .ref_req     (ref_req),
  .pre_all_cmd (pre_all_cmd),
  .ref_cmd     (ref_cmd),
  .cmd_block   (cmd_block),
  .ref_count   (ref_count),
  .sweep_done  (sweep_done)
);

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  localparam int NB = 4;
  localparam int SWEEP = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] interval_cfg = 16'd20;
  logic [7:0]  trfc_cfg = 8'd3;
  logic [NB-1:0] bank_idle = '1;
  logic        ref_gnt = 1'b0;
  logic        ref_req, pre_all_cmd, ref_cmd, cmd_block, sweep_done;
  logic [11:0] ref_count;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_sched u_sdram_refresh_sched (
    .clk(clk), .rst(rst), .interval_cfg(interval_cfg), .trfc_cfg(trfc_cfg),
    .bank_idle(bank_idle), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .pre_all_cmd(pre_all_cmd), .ref_cmd(ref_cmd), .cmd_block(cmd_block),
    .ref_count(ref_count), .sweep_done(sweep_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ref(input int lim, output int waited);
    waited = 0;
    while (!ref_cmd && waited < lim) begin
      step();
      waited++;
    end
  endtask

  // Sweep-count model: R7, also watches R5 on every cycle.
  int exp_cnt = 0;
  bit prev_ref = 0;
  int wraps = 0;
  always @(negedge clk) begin
    if (rst) begin
      exp_cnt  = 0;
      prev_ref = 0;
    end else begin
      if (prev_ref) begin
        exp_cnt = (exp_cnt + 1) % SWEEP;
        chk(ref_count == 12'(exp_cnt), "R7 count", int'(ref_count), exp_cnt);
        chk(sweep_done == (exp_cnt == 0), "R7 sweep_done", int'(sweep_done), int'(exp_cnt == 0));
        if (exp_cnt == 0) wraps++;
      end else if (sweep_done) begin
        chk(1'b0, "R7 stray sweep_done", 1, 0);
      end
      if (cmd_block && pre_all_cmd) chk(1'b0, "R5 precharge in hold-off", 1, 0);
      prev_ref = ref_cmd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    int gap;
    int len;
    int nref;
    repeat (3) step();
    // R1
    chk({ref_req, pre_all_cmd, ref_cmd, cmd_block, sweep_done} == 5'b0, "R1 outputs",
        int'({ref_req, pre_all_cmd, ref_cmd, cmd_block, sweep_done}), 0);
    chk(ref_count == 0, "R1 count", int'(ref_count), 0);
    rst = 1'b0;

    // R2 spacing and R6 hold-off length
    ref_gnt = 1'b1;
    wait_ref(100, w);
    step();
    wait_ref(100, gap);
    chk(gap + 1 == 20, "R2 spacing 20", gap + 1, 20);
    len = 0;
    while (cmd_block && len < 50) begin
      chk(ref_req == 1'b1, "R6 req during block", int'(ref_req), 1);
      step();
      len++;
    end
    chk(len == 3, "R6 block length 3", len, 3);
    chk(ref_req == 1'b0, "R6 req drops with block", int'(ref_req), 0);

    interval_cfg = 16'd13;
    wait_ref(100, w);
    step();
    wait_ref(100, gap);
    chk(gap + 1 == 13, "R2 spacing 13", gap + 1, 13);

    // R6 zero hold-off behaves as one
    trfc_cfg = 8'd0;
    step();
    wait_ref(100, w);
    len = 0;
    while (cmd_block && len < 50) begin step(); len++; end
    chk(len == 1, "R6 block length 0->1", len, 1);
    trfc_cfg = 8'd5;
    step();
    wait_ref(100, w);
    len = 0;
    while (cmd_block && len < 50) begin step(); len++; end
    chk(len == 5, "R6 block length 5", len, 5);

    // R3 and R8: hold grant low, then release
    interval_cfg = 16'd10;
    trfc_cfg = 8'd3;
    ref_gnt = 1'b0;
    w = 0;
    while (!ref_req && w < 100) begin step(); w++; end
    chk(ref_req == 1'b1, "R3 request raised", int'(ref_req), 1);
    nref = 0;
    for (int i = 0; i < 20; i++) begin
      if (ref_cmd || pre_all_cmd || !ref_req) nref++;
      step();
    end
    chk(nref == 0, "R3 held without commands", nref, 0);
    interval_cfg = 16'd1000;
    ref_gnt = 1'b1;
    nref = 0;
    for (int i = 0; i < 40; i++) begin
      if (ref_cmd) nref++;
      step();
    end
    chk(nref == 3, "R8 pending served", nref, 3);

    // R4: bank open at grant
    interval_cfg = 16'd10;
    ref_gnt = 1'b0;
    w = 0;
    while (!ref_req && w < 2000) begin step(); w++; end
    interval_cfg = 16'd1000;
    bank_idle = 4'b1011;
    ref_gnt = 1'b1;
    step();
    chk(pre_all_cmd == 1'b1, "R4 precharge first", int'(pre_all_cmd), 1);
    chk(ref_cmd == 1'b0, "R4 no refresh yet", int'(ref_cmd), 0);
    nref = 0;
    len = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (ref_cmd) nref++;
      if (pre_all_cmd) len++;
    end
    chk(nref == 0, "R4 refresh waits for idle", nref, 0);
    chk(len == 0, "R4 single precharge pulse", len, 0);
    bank_idle = '1;
    step();
    chk(ref_cmd == 1'b1, "R4 refresh after idle", int'(ref_cmd), 1);
    len = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (pre_all_cmd) len++;
    end
    chk(len == 0, "R5 no precharge after refresh", len, 0);

    // R7: run past one full sweep at the fastest rate (interval 0 acts as 1)
    interval_cfg = 16'd0;
    trfc_cfg = 8'd1;
    w = 0;
    while (wraps == 0 && w < 40000) begin step(); w++; end
    chk(wraps == 1, "R7 sweep wrap seen", wraps, 1);
    ref_gnt = 1'b0;
    repeat (20) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule